// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

The controller gathers interrupt requests from a watchdog overflow, eight external pins and fourteen on-chip peripheral pulses, and hands at most one of them at a time to a small CPU core as a 16-bit vector address. Each of the 23 maskable sources owns a pending flag, a mask flag and a level flag. A global enable and an in-service level decide which pending sources the CPU may take. The watchdog overflow can instead be routed to a non-maskable path, and a software break input enters its own service routine at a fixed address.

The CPU sees a level `irq_req`. To take the request it raises `take` for one cycle, and one cycle later the block returns `vec_stb` together with `vec_addr`. On entry the block saves the global enable and the in-service level on a small LIFO and clears the enable. A `reti` pulse restores the saved pair. External pins pass through a two-flop synchronizer and an edge detector that can be set per pin. `wake` tells the standby logic that an unmasked request is waiting, whatever the global enable is set to.

Top module: `irq_vectoring`

## Requirements
- R1: After reset every pending flag and every edge enable is 0, every mask flag and level flag is 1, the control register reads 3'b010 (enable 0, in-service level 1, watchdog routed maskable), and `irq_req`, `vec_stb` and `wake` are low.
- R2: The register port decodes `addr` as follows: 0 pending flags, 1 mask flags, 2 level flags, 3 rising-edge enables, 4 falling-edge enables, 5 control (bit0 global enable, bit1 in-service level, bit2 watchdog-to-non-maskable select). Bit n of the flag registers belongs to source n. A write to address 0 sets and clears pending flags directly. `rdata` shows the register selected by `addr` in the same cycle.
- R3: Source 0 is the watchdog overflow, sources 1 to 8 are external pins 0 to 7, and sources 9 to 22 are `per_req[0]` to `per_req[13]`. A one-cycle pulse sets the pending flag of its source.
- R4: A pin edge enabled for detection (rising, falling, or both when both enables are set) sets the pin's pending flag. The flag is visible on the third clock edge after the pin changes. A disabled edge sets nothing.
- R5: A maskable source is eligible only when its pending flag is 1, its mask flag is 0 and the global enable is 1. `irq_req` is high while any source, maskable or not, can be taken.
- R6: Among eligible sources, those with level flag 0 win over those with level flag 1. Inside a group the lowest source number wins. Sources that lose stay pending and are taken later.
- R7: While the in-service level is 0, sources with level flag 1 are held off, and sources with level flag 0 can still nest.
- R8: `take` while `irq_req` is high gives `vec_stb` for exactly one cycle after the next edge, with `vec_addr` = 0x0004 + 2 × source. The accepted pending flag is cleared, the global enable is cleared, and the in-service level takes the source's level flag.
- R9: Each entry pushes {global enable, in-service level} onto a LIFO of NEST entries, and `reti` pops and restores them. When the LIFO is full, no entry of any kind is accepted.
- R10: With the select bit set, a watchdog overflow raises a non-maskable request that is taken at vector 0x0004 whatever the global enable, and it leaves the pending flag of source 0 unchanged. A second non-maskable request waits until the first service returns.
- R11: `brk` enters at vector 0x003E whatever the global enable. It takes precedence over a `take` in the same cycle, and that `take` is dropped.
- R12: `wake` is high when any pending flag is unmasked or a non-maskable request is waiting, even with the global enable clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register select |
| wdata | input | 23 | Write data |
| rdata | output | 23 | Read data of the selected register |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| per_req | input | 14 | Peripheral request pulses |
| ext_pin | input | 8 | Asynchronous external interrupt pins |
| take | input | 1 | CPU takes the offered request |
| brk | input | 1 | Software break request |
| reti | input | 1 | Return from service |
| irq_req | output | 1 | A request can be taken |
| vec_stb | output | 1 | Vector valid, one cycle |
| vec_addr | output | 16 | Vector address |
| wake | output | 1 | Standby release |

## Verification
The bench goes through every source alone and then every pair of sources. A priority encoder that scanned from the wrong end, or that dropped the losing request, would hand out the wrong vector on the first take or nothing on the second. Nested entries with mixed level flags check that a level-1 request stays blocked under a level-0 service, and that the LIFO restores the enable and level of each layer in order; a single save register would restore the wrong pair. Every pin is run in each edge mode, with the synchronizer latency checked to the cycle. The non-maskable path, the break and the full LIFO are each checked for requests that must be refused.

// File: rtl/irq_vectoring.sv
module irq_vectoring #(
  parameter int N_EXT = 8,
  parameter int N_PER = 14,
  parameter int NEST  = 4,
  localparam int NM   = 1 + N_EXT + N_PER,
  localparam int IW   = $clog2(NM),
  localparam int SPW  = $clog2(NEST + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [NM-1:0]    wdata,
  output logic [NM-1:0]    rdata,
  input  logic             wdt_ovf,
  input  logic [N_PER-1:0] per_req,
  input  logic [N_EXT-1:0] ext_pin,
  input  logic             take,
  input  logic             brk,
  input  logic             reti,
  output logic             irq_req,
  output logic             vec_stb,
  output logic [15:0]      vec_addr,
  output logic             wake
);
  logic [NM-1:0] pend, mk, pr, pend_n;
  logic [N_EXT-1:0] egr, egf, s1, s2, s3;
  logic ie, isp, nmi_sel, nmi_pend, nmi_busy;
  logic [SPW-1:0] sp;
  logic [2**SPW-1:0] stk_ie, stk_isp, stk_nmi;
  logic [IW-1:0] sel;

  wire [N_EXT-1:0] ext_ev = (s2 & ~s3 & egr) | (~s2 & s3 & egf);
  wire [NM-1:0] hw_set = {per_req, ext_ev, wdt_ovf & ~nmi_sel};
  wire [NM-1:0] ok = pend & ~mk & (~pr | {NM{isp}});
  wire [NM-1:0] hi = ok & ~pr;
  wire [NM-1:0] cand = (|hi) ? hi : ok;
  wire can_push = sp < SPW'(NEST);
  wire nmi_go = nmi_pend & ~nmi_busy & can_push;
  wire mask_go = ie & (|ok) & can_push;
  wire acc_brk = brk & can_push;
  wire acc_int = take & irq_req & ~brk;
  wire acc = acc_brk | acc_int;
  wire do_ret = reti & ~acc & (sp != '0);
  wire [SPW-1:0] top = sp - SPW'(1);

  assign irq_req = nmi_go | mask_go;
  assign wake = nmi_pend | (|(pend & ~mk));

  always_comb begin
    sel = '0;
    for (int i = NM - 1; i >= 0; i--)
      if (cand[i]) sel = IW'(i);
  end

  always_comb begin
    pend_n = (wr_en && addr == 3'd0) ? wdata : pend;
    if (acc_int && !nmi_go) pend_n[sel] = 1'b0;
    pend_n = pend_n | hw_set;
  end

  always_comb begin
    case (addr)
      3'd0: rdata = pend;
      3'd1: rdata = mk;
      3'd2: rdata = pr;
      3'd3: rdata = NM'(egr);
      3'd4: rdata = NM'(egf);
      3'd5: rdata = NM'({nmi_sel, isp, ie});
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0; mk <= '1; pr <= '1; egr <= '0; egf <= '0;
      s1 <= '0; s2 <= '0; s3 <= '0;
      ie <= 1'b0; isp <= 1'b1; nmi_sel <= 1'b0;
      nmi_pend <= 1'b0; nmi_busy <= 1'b0; sp <= '0;
      stk_ie <= '0; stk_isp <= '0; stk_nmi <= '0;
      vec_stb <= 1'b0; vec_addr <= '0;
    end else begin
      s1 <= ext_pin; s2 <= s1; s3 <= s2;
      pend <= pend_n;
      vec_stb <= acc;
      nmi_pend <= (nmi_pend & ~(acc_int & nmi_go)) | (wdt_ovf & nmi_sel);
      if (wr_en) begin
        case (addr)
          3'd1: mk <= wdata;
          3'd2: pr <= wdata;
          3'd3: egr <= wdata[N_EXT-1:0];
          3'd4: egf <= wdata[N_EXT-1:0];
          3'd5: {nmi_sel, isp, ie} <= wdata[2:0];
          default: ;
        endcase
      end
      if (acc) begin
        stk_ie[sp] <= ie;
        stk_isp[sp] <= isp;
        stk_nmi[sp] <= ~acc_brk & nmi_go;
        sp <= sp + SPW'(1);
        ie <= 1'b0;
        if (acc_brk) vec_addr <= 16'h003E;
        else if (nmi_go) begin
          vec_addr <= 16'h0004;
          nmi_busy <= 1'b1;
        end else begin
          vec_addr <= 16'd4 + 16'({sel, 1'b0});
          isp <= pr[sel];
        end
      end else if (do_ret) begin
        sp <= top;
        ie <= stk_ie[top];
        isp <= stk_isp[top];
        if (stk_nmi[top]) nmi_busy <= 1'b0;
      end
    end
  end

  a_r8_take_gives_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (take && irq_req && !brk) |=> (vec_stb && !ie));
  a_r8_vector_range: assert property (@(posedge clk) disable iff (!rst_n)
    vec_stb |-> (!vec_addr[0] && vec_addr >= 16'h0004 && vec_addr <= 16'h003E));
  a_r11_break_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (brk && sp < SPW'(NEST)) |=> (vec_stb && vec_addr == 16'h003E));
  a_r12_wake_covers_req: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> wake);
  a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SPW'(NEST));
  a_r9_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
    do_ret |=> (sp == $past(sp) - SPW'(1)));
endmodule

// File: tb/irq_vectoring_bench.sv
module irq_vectoring_bench;
  localparam int NM = 23;
  logic clk = 0, rst_n = 0, wr_en = 0, wdt_ovf = 0, take = 0, brk = 0, reti = 0;
  logic [2:0] addr = 0;
  logic [NM-1:0] wdata = 0, rdata;
  logic [13:0] per_req = 0;
  logic [7:0] ext_pin = 0;
  logic irq_req, vec_stb, wake;
  logic [15:0] vec_addr;
  int total = 0, bad = 0;
  logic [NM-1:0] one = 1, rv;

  irq_vectoring u_irq_vectoring (.clk, .rst_n, .wr_en, .addr, .wdata, .rdata, .wdt_ovf,
    .per_req, .ext_pin, .take, .brk, .reti, .irq_req, .vec_stb, .vec_addr, .wake);

  always #2 clk = ~clk;

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin bad++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask
  task automatic wr(logic [2:0] a, logic [NM-1:0] d);
    addr = a; wdata = d; wr_en = 1; tick(); wr_en = 0;
  endtask
  task automatic rd(logic [2:0] a, output logic [NM-1:0] d);
    addr = a; #0.5; d = rdata;
  endtask
  task automatic do_take(); take = 1; tick(); take = 0; endtask
  task automatic do_reti(); reti = 1; tick(); reti = 0; endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    chk("R1 irq_req", irq_req, 0); chk("R1 vec_stb", vec_stb, 0); chk("R1 wake", wake, 0);
    rd(5, rv); chk("R1 control", rv, 3'b010);
    rd(1, rv); chk("R1 mask", rv, {NM{1'b1}});
    rd(2, rv); chk("R1 level", rv, {NM{1'b1}});
    rd(0, rv); chk("R1 pending", rv, 0);

    wr(1, 0); wr(5, 3'b011);
    rd(1, rv); chk("R2 mask write", rv, 0);
    for (int i = 0; i < NM; i++) begin
      wr(0, one << i);
      chk("R5 single irq_req", irq_req, 1);
      do_take();
      chk("R8 strobe", vec_stb, 1); chk("R8 vector", vec_addr, 4 + 2 * i);
      rd(0, rv); chk("R8 pending cleared", rv, 0);
      rd(5, rv); chk("R8 enable cleared", rv, 3'b010);
      tick(); chk("R8 strobe one cycle", vec_stb, 0);
      do_reti(); rd(5, rv); chk("R9 restore", rv, 3'b011);
    end

    for (int i = 0; i < NM; i++)
      for (int j = i + 1; j < NM; j++) begin
        wr(0, (one << i) | (one << j));
        do_take(); chk("R6 pair winner", vec_addr, 4 + 2 * i);
        do_reti(); chk("R6 loser pending", irq_req, 1);
        do_take(); chk("R6 loser vector", vec_addr, 4 + 2 * j);
        do_reti();
      end

    wr(1, one << 5); wr(0, one << 5);
    chk("R5 masked no req", irq_req, 0); chk("R12 masked no wake", wake, 0);
    wr(1, 0);
    chk("R5 unmasked req", irq_req, 1); chk("R12 unmasked wake", wake, 1);
    wr(5, 3'b010);
    chk("R5 enable clear no req", irq_req, 0); chk("R12 wake without enable", wake, 1);
    wr(0, 0); wr(5, 3'b011);

    wr(2, ~((one << 3) | (one << 7)));
    wr(0, (one << 2) | (one << 7));
    do_take(); chk("R6 level-0 group first", vec_addr, 4 + 14);
    rd(5, rv); chk("R8 level taken", rv, 3'b000);
    wr(5, 3'b001);
    chk("R7 level-1 held off", irq_req, 0);
    wr(0, (one << 2) | (one << 3));
    chk("R7 level-0 nests", irq_req, 1);
    do_take(); chk("R7 nested vector", vec_addr, 4 + 6);
    do_reti(); rd(5, rv); chk("R9 inner restore", rv, 3'b001);
    chk("R7 still held off", irq_req, 0);
    do_reti(); rd(5, rv); chk("R9 outer restore", rv, 3'b011);
    chk("R7 released", irq_req, 1);
    do_take(); chk("R6 remaining vector", vec_addr, 4 + 4);
    do_reti(); wr(2, '1);

    wr(5, 3'b110);
    wdt_ovf = 1; tick(); wdt_ovf = 0;
    rd(0, rv); chk("R10 pending untouched", rv, 0);
    chk("R10 nmi without enable", irq_req, 1);
    do_take(); chk("R10 nmi vector", vec_addr, 16'h0004);
    wdt_ovf = 1; tick(); wdt_ovf = 0;
    chk("R10 no renest", irq_req, 0);
    do_reti(); chk("R10 second nmi", irq_req, 1);
    do_take(); chk("R10 second vector", vec_addr, 16'h0004);
    do_reti(); chk("R10 drained", irq_req, 0);
    wr(5, 3'b010);
    wdt_ovf = 1; tick(); wdt_ovf = 0;
    rd(0, rv); chk("R3 watchdog maskable", rv, 1);
    chk("R5 watchdog needs enable", irq_req, 0);
    wr(0, 0);

    brk = 1; tick(); brk = 0;
    chk("R11 break strobe", vec_stb, 1); chk("R11 break vector", vec_addr, 16'h003E);
    do_reti();
    wr(5, 3'b011);
    for (int k = 0; k < 4; k++) begin
      brk = 1; tick(); brk = 0; chk("R9 push accepted", vec_stb, 1);
    end
    brk = 1; tick(); brk = 0; chk("R9 full refused", vec_stb, 0);
    wr(0, one << 1); chk("R9 full no req", irq_req, 0);
    for (int k = 0; k < 4; k++) do_reti();
    rd(5, rv); chk("R9 bottom restore", rv, 3'b011);
    wr(0, one << 4);
    take = 1; brk = 1; tick(); take = 0; brk = 0;
    chk("R11 break wins", vec_addr, 16'h003E);
    do_reti(); chk("R11 take dropped", irq_req, 1);
    do_take(); chk("R11 later vector", vec_addr, 4 + 8);
    do_reti(); wr(0, 0);

    per_req[0] = 1; tick(); per_req[0] = 0;
    rd(0, rv); chk("R3 peripheral 0", rv, one << 9); wr(0, 0);
    per_req[13] = 1; tick(); per_req[13] = 0;
    rd(0, rv); chk("R3 peripheral 13", rv, one << 22); wr(0, 0);

    wr(3, 8'h01); wr(4, 0);
    ext_pin[0] = 1; tick(); tick();
    rd(0, rv); chk("R4 latency two edges", rv, 0);
    tick(); rd(0, rv); chk("R4 latency three edges", rv, one << 1);
    tick(); wr(0, 0); ext_pin[0] = 0; repeat (4) tick(); wr(0, 0);

    for (int k = 0; k < 8; k++)
      for (int m = 1; m < 4; m++) begin
        wr(3, m[0] ? (8'h01 << k) : 8'h00);
        wr(4, m[1] ? (8'h01 << k) : 8'h00);
        ext_pin[k] = 1; repeat (4) tick();
        rd(0, rv); chk("R4 rising", rv, m[0] ? (one << (1 + k)) : 0);
        wr(0, 0);
        ext_pin[k] = 0; repeat (4) tick();
        rd(0, rv); chk("R4 falling", rv, m[1] ? (one << (1 + k)) : 0);
        wr(0, 0);
      end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule